// File: doc/BRIEF.md
# Post-Configuration Start-Up Sequencer

This block runs the start-up phase of a programmable device once its configuration data has been loaded. It watches the configuration-done level for a low-to-high change and then counts a fixed number of initialization clock ticks before it raises `user_mode`. The initialization clock is either a free-running internal oscillator (the default) or a clock supplied by the user. When the user clock is chosen, counting begins only after a fixed settle delay measured from the configuration-done rise.

Both clock sources reach the block as single-cycle enable strobes sampled on one fabric clock. The whole sequencer therefore lives in one clock domain, and the clock choice reduces to a choice between two enables.

The block also drives an optional "initialization finished" indicator of open-drain style: `initdone_pull_low` high means the pin is pulled low. The indicator is enabled by an option bit delivered with the first configuration frame. Once enabled, it holds the pin low until user mode starts. If the option is off, the pin is never pulled and stays at its pulled-up high level.

Top module: `init_startup_seq`

## Requirements
- R1: A clock edge with `rst` high sets `user_mode` and `initdone_pull_low` to 0, forgets the option bit and clears both counters. After reset, a fresh configuration-done rise is needed, followed by a full count.
- R2: The first edge after reset with `opt_strobe` high stores `opt_initdone_en`. Any later `opt_strobe` before the next reset is ignored.
- R3: When the stored option bit is 1, `initdone_pull_low` is 1 from the second edge after the accepted strobe until the edge that raises `user_mode`. When the bit is 0, `initdone_pull_low` stays 0.
- R4: A rise edge is an edge that samples `conf_done` at 1 when the previous edge sampled it at 0. The previous sample is taken as 1 during reset. Later falls and re-rises of `conf_done` have no effect until the next reset.
- R5: With `usr_clk_sel` = 0 at the rise edge, the internal-oscillator path is used. `osc_tick` is counted at every edge after the rise edge, and `user_mode` rises at the edge that samples the 299th such tick. `usr_tick` has no effect on this path.
- R6: With `usr_clk_sel` = 1 at the rise edge, the user-clock path is used. Ticks are ignored for `CD2CU_CYC` (default 12) edges after the rise edge. `usr_tick` is counted from the next edge on, and `user_mode` rises at the edge that samples the 299th counted tick. `osc_tick` has no effect on this path.
- R7: `usr_clk_sel` is sampled only at the rise edge. Later changes have no effect.
- R8: Ticks on either source before a rise edge have no effect: `user_mode` stays 0.
- R9: `initdone_pull_low` returns to 0 on the same edge that `user_mode` rises. `user_mode` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Configuration reset, synchronous, active high |
| conf_done | input | 1 | Configuration-done level |
| opt_strobe | input | 1 | Marks the option bit of the first frame as valid |
| opt_initdone_en | input | 1 | Option bit enabling the indicator pin |
| usr_clk_sel | input | 1 | 1 selects the user clock for initialization |
| osc_tick | input | 1 | One-cycle tick of the internal oscillator |
| usr_tick | input | 1 | One-cycle tick of the user clock |
| initdone_pull_low | output | 1 | 1 pulls the indicator pin low |
| user_mode | output | 1 | Device has entered user mode |

## Verification
An off-by-one in either counter moves the `user_mode` rise by exactly one counted tick. With the sparse tick patterns used, this is a whole tick period, so the cycle-exact check of the rise edge catches it at once. If the clock choice or the option bit were re-sampled late, the rise would move to the other source's timetable or the pin-pull level would flip on the next edge, so a fault appears within the run it occurs in. A counter that reset does not clear shows up as an early `user_mode` after the second rise.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SETTLE,
    SEQ_COUNT,
    SEQ_USER
  } seq_state_t;
endpackage

// File: rtl/init_opt_latch.sv
module init_opt_latch (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic bit_in,
  output logic en_q
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (strobe && !seen_q) begin
      seen_q <= 1'b1;
      en_q   <= bit_in;
    end
  end

  // R2
  opt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    seen_q |=> $stable(en_q));
endmodule

// File: rtl/init_tick_sel.sv
module init_tick_sel (
  input  logic clk,
  input  logic rst,
  input  logic lock,
  input  logic sel_in,
  input  logic osc_tick,
  input  logic usr_tick,
  output logic sel_q,
  output logic tick
);
  logic locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= 1'b0;
      locked_q <= 1'b0;
    end else if (lock && !locked_q) begin
      sel_q    <= sel_in;
      locked_q <= 1'b1;
    end
  end

  assign tick = sel_q ? usr_tick : osc_tick;

  // R7
  sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> $stable(sel_q));
endmodule

// File: rtl/init_span_counter.sv
module init_span_counter #(
  parameter int LIMIT = 299
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  assign last = en && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= last ? '0 : cnt + 1'b1;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < W'(LIMIT));
endmodule

// File: rtl/init_startup_seq.sv
module init_startup_seq #(
  parameter int INIT_CYC  = 299,
  parameter int CD2CU_CYC = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic conf_done,
  input  logic opt_strobe,
  input  logic opt_initdone_en,
  input  logic usr_clk_sel,
  input  logic osc_tick,
  input  logic usr_tick,
  output logic initdone_pull_low,
  output logic user_mode
);
  import init_seq_pkg::*;

  seq_state_t state;
  logic       cd_q, rise, opt_en, sel_q, tick;
  logic       settle_last, count_last, um_next;

  assign rise = conf_done && !cd_q;

  always_ff @(posedge clk) begin
    if (rst) cd_q <= 1'b1;
    else     cd_q <= conf_done;
  end

  init_opt_latch u_opt (
    .clk(clk), .rst(rst), .strobe(opt_strobe),
    .bit_in(opt_initdone_en), .en_q(opt_en)
  );

  init_tick_sel u_sel (
    .clk(clk), .rst(rst), .lock(rise && state == SEQ_IDLE),
    .sel_in(usr_clk_sel), .osc_tick(osc_tick), .usr_tick(usr_tick),
    .sel_q(sel_q), .tick(tick)
  );

  init_span_counter #(.LIMIT(CD2CU_CYC)) u_settle (
    .clk(clk), .rst(rst), .clr(state != SEQ_SETTLE),
    .en(state == SEQ_SETTLE), .last(settle_last)
  );

  init_span_counter #(.LIMIT(INIT_CYC)) u_count (
    .clk(clk), .rst(rst), .clr(state != SEQ_COUNT),
    .en(state == SEQ_COUNT && tick), .last(count_last)
  );

  assign um_next = (state == SEQ_USER) || (state == SEQ_COUNT && count_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state             <= SEQ_IDLE;
      user_mode         <= 1'b0;
      initdone_pull_low <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE:   if (rise) state <= usr_clk_sel ? SEQ_SETTLE : SEQ_COUNT;
        SEQ_SETTLE: if (settle_last) state <= SEQ_COUNT;
        SEQ_COUNT:  if (count_last) state <= SEQ_USER;
        default:    state <= SEQ_USER;
      endcase
      user_mode         <= um_next;
      initdone_pull_low <= opt_en && !um_next;
    end
  end

  // R9
  um_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    user_mode |=> user_mode);
  // R5
  um_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(user_mode) |-> $past(tick));
  // R9
  pin_released_chk: assert property (@(posedge clk) disable iff (rst)
    user_mode |-> !initdone_pull_low);
  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (!user_mode && !initdone_pull_low));
endmodule

// File: tb/tb_init_startup_seq.sv
module tb_init_startup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int INIT = 299;
  localparam int DLY  = 12;

  logic clk = 0, rst = 1, conf_done = 0, opt_strobe = 0, opt_initdone_en = 0;
  logic usr_clk_sel = 0, osc_tick = 0, usr_tick = 0;
  logic initdone_pull_low, user_mode;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  init_startup_seq dut (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_step();
    @(posedge clk); #1;
  endtask

  function automatic bit tick_at(bit usr, int t, int p, int ph);
    if (usr) return (t % (p + 1)) == 0;
    return (t % p) == (ph % p);
  endfunction

  function automatic int finish_edge(bit sel, int p, int ph);
    int start = sel ? DLY : 0;
    int cnt = 0;
    for (int t = start + 1; t < 100000; t++) begin
      if (tick_at(sel, t, p, ph)) cnt++;
      if (cnt == INIT) return t;
    end
    return -1;
  endfunction

  task automatic do_reset();
    rst = 1; conf_done = 0; opt_strobe = 0; osc_tick = 0; usr_tick = 0;
    repeat (2) edge_step();
    chk("R1 reset user_mode", user_mode, 1'b0);
    chk("R1 reset pull", initdone_pull_low, 1'b0);
    rst = 0;
  endtask

  // full sequence; drop_cd exercises R4
  task automatic run_seq(bit sel, bit opt, int p, int ph, bit drop_cd);
    int fin;
    do_reset();
    opt_strobe = 1; opt_initdone_en = opt;
    osc_tick = 1; usr_tick = 1;          // R8: pre-rise ticks
    edge_step();
    opt_initdone_en = !opt;              // R2: second strobe ignored
    edge_step();
    opt_strobe = 0;
    repeat (3) edge_step();
    chk("R8 no start before rise", user_mode, 1'b0);
    chk("R2/R3 option level", initdone_pull_low, opt);
    fin = finish_edge(sel, p, ph);
    usr_clk_sel = sel; conf_done = 1;
    for (int t = 0; t <= fin + 2; t++) begin
      osc_tick = tick_at(0, t, p, ph);
      usr_tick = tick_at(1, t, p, ph);
      if (t == 1) usr_clk_sel = !sel;    // R7: late change
      if (drop_cd && t == DLY + 3) conf_done = 0;
      if (drop_cd && t == DLY + 5) conf_done = 1;
      edge_step();
      if (t == fin - 1 || t == fin || t == fin + 2 || t == DLY || t == 3) begin
        chk(sel ? "R6/R7 user_mode timing" : "R5/R7 user_mode timing",
            user_mode, t >= fin);
        chk("R3/R9 pull timing", initdone_pull_low, opt && (t < fin));
      end
    end
    osc_tick = 0; usr_tick = 0;
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 2; o++)
        for (int p = 1; p <= 3; p++)
          run_seq(s[0], o[0], p, p - 1, p == 2);

    // R1: reset mid-count clears counters and option
    do_reset();
    usr_clk_sel = 0; conf_done = 1; osc_tick = 1;
    repeat (150) edge_step();
    do_reset();
    chk("R1 option forgotten", initdone_pull_low, 1'b0);
    osc_tick = 1;
    repeat (400) edge_step();
    chk("R1/R8 idle without rise", user_mode, 1'b0);
    conf_done = 1;
    edge_step();
    repeat (INIT - 1) edge_step();
    chk("R1 counter cleared, not yet", user_mode, 1'b0);
    edge_step();
    chk("R1/R5 full count after reset", user_mode, 1'b1);
    chk("R3 no option no pull", initdone_pull_low, 1'b0);
    repeat (5) edge_step();
    chk("R9 user_mode sticky", user_mode, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule